// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block raises interrupts for a group of DMA channels. Each channel has a word counter. Software can load the counter directly, which starts a single unchained block. A descriptor fetch can also load it, together with the pointer to the next descriptor, which marks the block as part of a chain. Every completed word transfer pulses a per-channel strobe that counts the counter down. The transfer that takes the counter from one to zero is the completion event.

For a chained block, a per-channel option chooses the interrupt policy. With the option set, every block in the chain raises its own interrupt. With it clear, only the block loaded with a zero next-descriptor pointer raises one. When a channel's counter is zero, the channel is idle, and each single-word access to its buffer raises that channel's interrupt instead.

Events set per-channel latch bits whatever the mask holds. The mask only decides which latched bits reach the combined request output, and that output is registered. Software clears latched bits by writing ones to their positions.

Top module: `dma_done_irq`

## Requirements
- R1: After software loads count N (N ≥ 1) into a channel, the channel's latch bit stays clear through the first N−1 transfer strobes. It is set on the clock edge of the N-th strobe.
- R2: A transfer strobe on a channel whose count is zero leaves the count and the latch unchanged.
- R3: For a chained block with the per-block option set, the latch is set at the end of every block, whatever the next-descriptor pointer holds.
- R4: For a chained block with the per-block option clear, the latch is set only at the end of a block that was loaded with a next-descriptor pointer of zero.
- R5: A software write of zero to the count raises no interrupt, even while a transfer is in progress. Later transfer strobes on that channel then have no effect.
- R6: A software write of one to the count during a transfer stops it early. Exactly one more transfer strobe sets the latch.
- R7: A buffer-access strobe sets the channel's latch when the channel's count is zero. It has no effect while the count is non-zero.
- R8: Latch bits are set regardless of the mask value.
- R9: `irqReq` equals the OR of (latch AND mask) as it stood one clock earlier.
- R10: Writing with `clrWrEn` clears every latch bit that has a one in `clrWrData`. If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: In reset all latch bits, all mask bits, `irqReq` and all counts are zero.
- R12: A count write or descriptor load in the same cycle as a transfer strobe on that channel takes priority. The load happens, no decrement occurs, and no completion event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntWrEn | input | NUM_CH | Per-channel software count write strobe (unchained load) |
| cntWrData | input | CNT_W | Count value for software writes |
| descLoad | input | NUM_CH | Per-channel descriptor load strobe (chained block) |
| descCount | input | CNT_W | Count from the loaded descriptor |
| descNext | input | PTR_W | Next-descriptor pointer of the loaded descriptor; zero marks the last block |
| perBlockIrq | input | NUM_CH | Per-channel chain policy: 1 = interrupt every block, 0 = chain end only |
| xferDone | input | NUM_CH | Per-channel one-cycle word-transferred strobe |
| bufAccess | input | NUM_CH | Per-channel single-word buffer access strobe |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | NUM_CH | New mask value (1 = enabled) |
| clrWrEn | input | 1 | Latch clear strobe |
| clrWrData | input | NUM_CH | Write-one-to-clear pattern |
| irqLatch | output | NUM_CH | Latched interrupt bits |
| irqReq | output | 1 | Combined, registered interrupt request |

## Verification
The bound checker covers the cycle-level rules on every cycle:
- a latch bit never rises without a transfer or buffer strobe in the cycle before;
- a count write with no buffer access never raises a clear latch bit;
- a clear with no competing strobe always empties the bit;
- the request stays low after a cycle with all latches clear.

Only the bench's scenarios show the rest: that the interrupt arrives on exactly the N-th strobe, that the chain policies select the right blocks, that writing one stops a transfer after one word, and the exact mask and latch combinations seen on the request.

// File: rtl/dma_done_irq_pkg.sv
package dma_done_irq_pkg;

  // Per-channel strobes from control to the counter datapath.
  typedef struct packed {
    logic loadSw;    // software count write
    logic loadDesc;  // descriptor load (chained block)
    logic dec;       // count down by one
  } chStrobe_t;

  // Per-channel status from the datapath back to control.
  typedef struct packed {
    logic cntZero;
    logic cntOne;
    logic chained;
    logic lastBlk;
  } chStat_t;

endpackage

// File: rtl/dma_done_irq_dp.sv
module dma_done_irq_dp
  import dma_done_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStrobe_t        strb [NUM_CH],
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [CNT_W-1:0] descCount,
  input  logic [PTR_W-1:0] descNext,
  output chStat_t          stat [NUM_CH]
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic descIsLast;
  assign descIsLast = (descNext == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] cntQ;
    logic             chainedQ;
    logic             lastQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ     <= '0;
        chainedQ <= 1'b0;
        lastQ    <= 1'b0;
      end else if (strb[ch].loadSw) begin
        cntQ     <= cntWrData;
        chainedQ <= 1'b0;
        lastQ    <= 1'b0;
      end else if (strb[ch].loadDesc) begin
        cntQ     <= descCount;
        chainedQ <= 1'b1;
        lastQ    <= descIsLast;
      end else if (strb[ch].dec) begin
        cntQ     <= cntQ - CNT_ONE;
      end
    end

    assign stat[ch].cntZero = (cntQ == '0);
    assign stat[ch].cntOne  = (cntQ == CNT_ONE);
    assign stat[ch].chained = chainedQ;
    assign stat[ch].lastBlk = lastQ;
  end

endmodule

// File: rtl/dma_done_irq_ctrl.sv
module dma_done_irq_ctrl
  import dma_done_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cntWrEn,
  input  logic [NUM_CH-1:0] descLoad,
  input  logic [NUM_CH-1:0] perBlockIrq,
  input  logic [NUM_CH-1:0] xferDone,
  input  logic [NUM_CH-1:0] bufAccess,
  input  logic              maskWrEn,
  input  logic [NUM_CH-1:0] maskWrData,
  input  logic              clrWrEn,
  input  logic [NUM_CH-1:0] clrWrData,
  input  chStat_t           stat [NUM_CH],
  output chStrobe_t         strb [NUM_CH],
  output logic [NUM_CH-1:0] irqLatch,
  output logic [NUM_CH-1:0] maskQ,
  output logic              irqReq
);

  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] clrVec;
  logic [NUM_CH-1:0] latchQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_evt
    logic anyLoad;
    logic doneEvt;
    logic policyOk;
    logic idleHit;

    assign anyLoad  = cntWrEn[ch] | descLoad[ch];
    assign doneEvt  = xferDone[ch] & ~anyLoad & stat[ch].cntOne;
    assign policyOk = ~stat[ch].chained | perBlockIrq[ch] | stat[ch].lastBlk;
    assign idleHit  = bufAccess[ch] & stat[ch].cntZero;

    assign strb[ch].loadSw   = cntWrEn[ch];
    assign strb[ch].loadDesc = descLoad[ch] & ~cntWrEn[ch];
    assign strb[ch].dec      = xferDone[ch] & ~anyLoad & ~stat[ch].cntZero;

    assign setVec[ch] = (doneEvt & policyOk) | idleHit;
  end

  assign clrVec = clrWrEn ? clrWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      maskQ  <= '0;
      irqReq <= 1'b0;
    end else begin
      latchQ <= (latchQ & ~clrVec) | setVec;
      if (maskWrEn) maskQ <= maskWrData;
      irqReq <= |(latchQ & maskQ);
    end
  end

  assign irqLatch = latchQ;

endmodule

// File: rtl/dma_done_irq.sv
module dma_done_irq
  import dma_done_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [NUM_CH-1:0] descLoad,
  input  logic [CNT_W-1:0]  descCount,
  input  logic [PTR_W-1:0]  descNext,
  input  logic [NUM_CH-1:0] perBlockIrq,
  input  logic [NUM_CH-1:0] xferDone,
  input  logic [NUM_CH-1:0] bufAccess,
  input  logic              maskWrEn,
  input  logic [NUM_CH-1:0] maskWrData,
  input  logic              clrWrEn,
  input  logic [NUM_CH-1:0] clrWrData,
  output logic [NUM_CH-1:0] irqLatch,
  output logic              irqReq
);

  chStrobe_t         strb [NUM_CH];
  chStat_t           stat [NUM_CH];
  logic [NUM_CH-1:0] maskQ;

  dma_done_irq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntWrEn    (cntWrEn),
    .descLoad   (descLoad),
    .perBlockIrq(perBlockIrq),
    .xferDone   (xferDone),
    .bufAccess  (bufAccess),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .clrWrEn    (clrWrEn),
    .clrWrData  (clrWrData),
    .stat       (stat),
    .strb       (strb),
    .irqLatch   (irqLatch),
    .maskQ      (maskQ),
    .irqReq     (irqReq)
  );

  dma_done_irq_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cntWrData(cntWrData),
    .descCount(descCount),
    .descNext (descNext),
    .stat     (stat)
  );

endmodule

// File: rtl/dma_done_irq_chk.sv
module dma_done_irq_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cntWrEn,
  input logic [NUM_CH-1:0] xferDone,
  input logic [NUM_CH-1:0] bufAccess,
  input logic              clrWrEn,
  input logic [NUM_CH-1:0] clrWrData,
  input logic [NUM_CH-1:0] irqLatch,
  input logic              irqReq
);

  // R1/R7: a latch bit only rises after a transfer or buffer strobe on its channel
  assert_latch_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((irqLatch & ~$past(irqLatch) & ~$past(xferDone | bufAccess)) == '0));

  // R9: with nothing latched, the request is low in the next cycle
  assert_req_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqLatch == '0) |=> !irqReq);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R5/R12: a count write alone never raises a clear latch bit
    assert_wr_no_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      (cntWrEn[ch] && !bufAccess[ch] && !irqLatch[ch]) |=> !irqLatch[ch]);

    // R10: a clear with no competing strobe empties the bit
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rstN)
      (clrWrEn && clrWrData[ch] && !xferDone[ch] && !bufAccess[ch]) |=> !irqLatch[ch]);
  end

endmodule

bind dma_done_irq dma_done_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cntWrEn  (cntWrEn),
  .xferDone (xferDone),
  .bufAccess(bufAccess),
  .clrWrEn  (clrWrEn),
  .clrWrData(clrWrData),
  .irqLatch (irqLatch),
  .irqReq   (irqReq)
);

// File: tb/test_dma_done_irq.sv
`timescale 1ns/1ps
module test_dma_done_irq;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int PTR_W  = 8;
  localparam real CLK_HALF = 2.5;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NUM_CH-1:0] cntWrEn, descLoad, perBlockIrq, xferDone, bufAccess;
  logic [CNT_W-1:0]  cntWrData, descCount;
  logic [PTR_W-1:0]  descNext;
  logic              maskWrEn, clrWrEn;
  logic [NUM_CH-1:0] maskWrData, clrWrData;
  logic [NUM_CH-1:0] irqLatch;
  logic              irqReq;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_HALF) clk = ~clk;

  dma_done_irq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PTR_W(PTR_W)) i_dma_done_irq (
    .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .descLoad(descLoad), .descCount(descCount), .descNext(descNext),
    .perBlockIrq(perBlockIrq), .xferDone(xferDone), .bufAccess(bufAccess),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .clrWrEn(clrWrEn),
    .clrWrData(clrWrData), .irqLatch(irqLatch), .irqReq(irqReq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: strobes set before the call are applied at the edge, then dropped.
  task automatic tick();
    @(posedge clk);
    #1;
    cntWrEn = '0; descLoad = '0; xferDone = '0; bufAccess = '0;
    maskWrEn = 1'b0; clrWrEn = 1'b0;
  endtask

  task automatic clearAll();
    clrWrEn = 1'b1; clrWrData = '1; tick();
  endtask

  task automatic swCount(int ch, int val);
    cntWrEn[ch] = 1'b1; cntWrData = CNT_W'(val); tick();
  endtask

  task automatic xfer(int ch);
    xferDone[ch] = 1'b1; tick();
  endtask

  initial begin
    rstN = 1'b0;
    cntWrEn = '0; descLoad = '0; xferDone = '0; bufAccess = '0;
    perBlockIrq = '0; maskWrEn = 1'b0; clrWrEn = 1'b0;
    cntWrData = '0; descCount = '0; descNext = '0; maskWrData = '0; clrWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 latch", 32'(irqLatch), 0);
    chk("R11 irqReq", 32'(irqReq), 0);
    rstN = 1'b1;
    tick();
    // R11: counts zero -> idle buffer access sets latch
    bufAccess = '1; tick();
    chk("R11 counts zero", 32'(irqLatch), 32'hF);
    chk("R11 mask zero", 32'(irqReq), 0);
    clearAll();

    // R1 / R2 sweep: every channel, counts 1..5
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int n = 1; n <= 5; n++) begin
        swCount(ch, n);
        for (int k = 1; k <= n; k++) begin
          xfer(ch);
          chk("R1 count-down", 32'(irqLatch), (k == n) ? (32'd1 << ch) : 32'd0);
        end
        clearAll();
        xfer(ch);
        chk("R2 strobe at zero", 32'(irqLatch), 0);
      end
    end

    // R5: write zero mid-transfer
    swCount(1, 5); xfer(1); xfer(1);
    swCount(1, 0);
    chk("R5 write zero", 32'(irqLatch), 0);
    for (int k = 0; k < 4; k++) xfer(1);
    chk("R5 after zero", 32'(irqLatch), 0);

    // R6: write one mid-transfer
    swCount(2, 6); xfer(2); xfer(2);
    swCount(2, 1);
    chk("R6 write one", 32'(irqLatch), 0);
    xfer(2);
    chk("R6 one more word", 32'(irqLatch), 32'h4);
    clearAll();

    // R3 / R4: three-block chains on channel 0
    for (int pb = 0; pb < 2; pb++) begin
      perBlockIrq[0] = pb[0];
      for (int len = 1; len <= 3; len++) begin
        for (int blk = 0; blk < 3; blk++) begin
          descLoad[0] = 1'b1; descCount = CNT_W'(len);
          descNext = (blk < 2) ? PTR_W'(8'h40 + blk) : '0;
          tick();
          for (int k = 1; k <= len; k++) begin
            xfer(0);
            if (k < len) chk(pb ? "R3 mid-block" : "R4 mid-block", 32'(irqLatch), 0);
          end
          chk(pb ? "R3 block end" : "R4 block end", 32'(irqLatch),
              (pb == 1 || blk == 2) ? 32'd1 : 32'd0);
          clearAll();
        end
      end
    end
    perBlockIrq = '0;

    // R7: single-word access idle vs busy
    bufAccess[1] = 1'b1; tick();
    chk("R7 idle access", 32'(irqLatch), 32'h2);
    clearAll();
    swCount(3, 3);
    bufAccess[3] = 1'b1; tick();
    chk("R7 busy access ignored", 32'(irqLatch), 0);
    swCount(3, 0);

    // R8 / R9: all latch patterns against all masks
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        maskWrEn = 1'b1; maskWrData = NUM_CH'(m);
        clrWrEn = 1'b1; clrWrData = '1;
        tick();
        bufAccess = NUM_CH'(p); tick();
        chk("R8 latch ignores mask", 32'(irqLatch), 32'(p));
        chk("R9 request delayed", 32'(irqReq), 0);
        tick();
        chk("R9 masked OR", 32'(irqReq), ((p & m) != 0) ? 32'd1 : 32'd0);
      end
    end
    maskWrEn = 1'b1; maskWrData = '0; tick();
    clearAll();

    // R10: set and clear collide
    bufAccess[2] = 1'b1; clrWrEn = 1'b1; clrWrData = 4'h4; tick();
    chk("R10 set wins", 32'(irqLatch), 32'h4);
    bufAccess[0] = 1'b1; tick();
    clrWrEn = 1'b1; clrWrData = 4'h4; tick();
    chk("R10 w1c selective", 32'(irqLatch), 32'h1);
    clearAll();

    // R12: loads win over a simultaneous strobe
    swCount(0, 2); xfer(0);
    xferDone[0] = 1'b1; cntWrEn[0] = 1'b1; cntWrData = 8'd4; tick();
    chk("R12 sw load wins", 32'(irqLatch), 0);
    for (int k = 1; k <= 4; k++) begin
      xfer(0);
      chk("R12 reloaded count", 32'(irqLatch), (k == 4) ? 32'd1 : 32'd0);
    end
    clearAll();
    swCount(1, 1);
    xferDone[1] = 1'b1; descLoad[1] = 1'b1; descCount = 8'd2; descNext = '0; tick();
    chk("R12 desc load wins", 32'(irqLatch), 0);
    xfer(1);
    chk("R12 desc mid", 32'(irqLatch), 0);
    xfer(1);
    chk("R12 desc end", 32'(irqLatch), 32'h2);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule